// File: doc/BRIEF.md
# Thread-Command Concentrator

Each processor core runs several hardware thread contexts, and any of them may issue a thread-management command (create, join, exit, lock and similar) that only a single shared management unit can serve. This block sits inside the core and funnels those commands to that unit. Each cycle it looks at the contexts that are both running and requesting. When no command is in flight, it picks one of them in rotating order and latches that context's opcode and argument. It then presents them unchanged to the central unit together with the number of the issuing context.

Exactly one command per core is in flight at a time. A requesting context sees its stall line high until the central unit reports completion. In that completion cycle the returned value is steered to the issuing context alone, through its own response-valid line. The context lowers its request at the following clock edge. A context that is halted is left out of arbitration even when its request line is high.

Top module: `tcq_concentrator`

## Requirements
- R1: While reset is high and in the first cycle after it, `cu_req_valid` is 0 and every bit of `ctx_rsp_valid` is 0.
- R2: A running, requesting context that wins while nothing is in flight sees its opcode and argument on `cu_req_op`/`cu_req_arg` one clock edge later. At that point `cu_req_valid` is 1 and `cu_req_src` holds the context index (context i drives bits i*OP_W and i*ARG_W upward of the flattened request buses).
- R3: While `cu_req_valid` is 1 and `cu_done` is 0, the request stays valid and opcode, argument and source do not change, whatever the contexts drive. No second command is issued.
- R4: In a cycle with `cu_req_valid` and `cu_done` both 1, only bit `cu_req_src` of `ctx_rsp_valid` is 1 and `ctx_rsp_data` equals `cu_ret`. The response is combinational with `cu_done`.
- R5: Selection rotates. After reset, context 0 has top priority. After context k is served, the search starts at k+1 and wraps, so two contexts that request without pause are served alternately.
- R6: A context whose `ctx_active` bit is 0 is never selected, even with its request high. It becomes eligible at the edge after it is set active.
- R7: `ctx_stall[i]` is 1 in every cycle that context i requests, except the cycle in which its response is presented.
- R8: `cu_done` while nothing is in flight is ignored: no response bit rises and no command is issued.
- R9: In the cycle after a completion, `cu_req_valid` is 0. The next command is issued one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_active | input | N_CTX | Context running (1) or halted (0) |
| ctx_req | input | N_CTX | Context has a command pending |
| ctx_op | input | N_CTX*OP_W | Per-context opcodes, context i at bits i*OP_W upward |
| ctx_arg | input | N_CTX*ARG_W | Per-context arguments, context i at bits i*ARG_W upward |
| ctx_stall | output | N_CTX | Per-context stall |
| ctx_rsp_valid | output | N_CTX | Per-context response strobe |
| ctx_rsp_data | output | RET_W | Returned value, qualified by `ctx_rsp_valid` |
| cu_req_valid | output | 1 | Command in flight toward the central unit |
| cu_req_op | output | OP_W | Opcode in flight |
| cu_req_arg | output | ARG_W | Argument in flight |
| cu_req_src | output | idx_w(N_CTX) | Issuing context index |
| cu_done | input | 1 | Central unit completion strobe |
| cu_ret | input | RET_W | Central unit return value |

## Verification
A request raised between edges produces the command on the central-unit port after exactly one rising edge. The bench therefore drives inputs on the falling edge and checks the command fields at the next falling edge. Responses and stall release follow `cu_done` with no register, so they are checked 1 ns after `cu_done` is driven, before any edge. The mandatory idle cycle and the next grant are then checked at the two falling edges that follow.

// File: rtl/tcq_pkg.sv
package tcq_pkg;

    localparam int OP_W  = 4;
    localparam int ARG_W = 32;
    localparam int RET_W = 32;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [ARG_W-1:0] arg;
    } tcmd_t;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_BUSY = 1'b1
    } slot_state_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tcq_rr_pick.sv
module tcq_rr_pick #(
    parameter int N  = 2,
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  elig,
    input  logic          take,
    output logic          any,
    output logic [IW-1:0] win
);
    logic [IW-1:0] last;
    int            idx;

    // search starts one past the last served context and wraps
    always_comb begin
        any = 1'b0;
        win = '0;
        idx = 0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(last) + k) % N;
            if (!any && elig[idx]) begin
                any = 1'b1;
                win = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last <= IW'(N - 1);
        end else if (take) begin
            last <= win;
        end
    end
endmodule

// File: rtl/tcq_slot.sv
module tcq_slot
    import tcq_pkg::*;
#(
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [IW-1:0] win,
    input  tcmd_t         win_cmd,
    input  logic          cu_done,
    output logic          busy,
    output logic [IW-1:0] owner,
    output tcmd_t         cmd
);
    slot_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SLOT_IDLE;
            owner <= '0;
            cmd   <= '0;
        end else begin
            case (state)
                SLOT_IDLE: if (take) begin
                    state <= SLOT_BUSY;
                    owner <= win;
                    cmd   <= win_cmd;
                end
                SLOT_BUSY: if (cu_done) begin
                    state <= SLOT_IDLE;
                end
                default: state <= SLOT_IDLE;
            endcase
        end
    end

    assign busy = (state == SLOT_BUSY);
endmodule

// File: rtl/tcq_rsp_route.sv
module tcq_rsp_route
    import tcq_pkg::*;
#(
    parameter int N  = 2,
    parameter int IW = 1
) (
    input  logic             busy,
    input  logic [IW-1:0]    owner,
    input  logic             cu_done,
    input  logic [RET_W-1:0] cu_ret,
    input  logic [N-1:0]     ctx_req,
    output logic [N-1:0]     rsp_valid,
    output logic [RET_W-1:0] rsp_data,
    output logic [N-1:0]     stall
);
    logic finish;
    assign finish   = busy & cu_done;
    assign rsp_data = finish ? cu_ret : '0;

    for (genvar i = 0; i < N; i++) begin : g_ctx
        assign rsp_valid[i] = finish && (owner == IW'(i));
        assign stall[i]     = ctx_req[i] & ~rsp_valid[i];
    end
endmodule

// File: rtl/tcq_concentrator.sv
module tcq_concentrator
    import tcq_pkg::*;
#(
    parameter int N_CTX = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_CTX-1:0]              ctx_active,
    input  logic [N_CTX-1:0]              ctx_req,
    input  logic [N_CTX*OP_W-1:0]         ctx_op,
    input  logic [N_CTX*ARG_W-1:0]        ctx_arg,
    output logic [N_CTX-1:0]              ctx_stall,
    output logic [N_CTX-1:0]              ctx_rsp_valid,
    output logic [RET_W-1:0]              ctx_rsp_data,
    output logic                          cu_req_valid,
    output logic [OP_W-1:0]               cu_req_op,
    output logic [ARG_W-1:0]              cu_req_arg,
    output logic [idx_w(N_CTX)-1:0]       cu_req_src,
    input  logic                          cu_done,
    input  logic [RET_W-1:0]              cu_ret
);
    localparam int IW = idx_w(N_CTX);

    tcmd_t         cmds [N_CTX];
    tcmd_t         held;
    logic          any, busy, take;
    logic [IW-1:0] win, owner;

    for (genvar i = 0; i < N_CTX; i++) begin : g_unpack
        assign cmds[i].op  = ctx_op[i*OP_W +: OP_W];
        assign cmds[i].arg = ctx_arg[i*ARG_W +: ARG_W];
    end

    assign take = any & ~busy;

    tcq_rr_pick #(.N(N_CTX), .IW(IW)) u_pick (
        .clk  (clk),
        .rst  (rst),
        .elig (ctx_req & ctx_active),
        .take (take),
        .any  (any),
        .win  (win)
    );

    tcq_slot #(.IW(IW)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .win     (win),
        .win_cmd (cmds[win]),
        .cu_done (cu_done),
        .busy    (busy),
        .owner   (owner),
        .cmd     (held)
    );

    tcq_rsp_route #(.N(N_CTX), .IW(IW)) u_route (
        .busy      (busy),
        .owner     (owner),
        .cu_done   (cu_done),
        .cu_ret    (cu_ret),
        .ctx_req   (ctx_req),
        .rsp_valid (ctx_rsp_valid),
        .rsp_data  (ctx_rsp_data),
        .stall     (ctx_stall)
    );

    assign cu_req_valid = busy;
    assign cu_req_op    = held.op;
    assign cu_req_arg   = held.arg;
    assign cu_req_src   = owner;
endmodule

// File: rtl/tcq_concentrator_chk.sv
module tcq_concentrator_chk
    import tcq_pkg::*;
#(
    parameter int N_CTX = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [N_CTX-1:0]        ctx_active,
    input logic [N_CTX-1:0]        ctx_req,
    input logic [N_CTX-1:0]        ctx_rsp_valid,
    input logic                    cu_req_valid,
    input logic [OP_W-1:0]         cu_req_op,
    input logic [ARG_W-1:0]        cu_req_arg,
    input logic [idx_w(N_CTX)-1:0] cu_req_src,
    input logic                    cu_done
);
    logic [N_CTX-1:0] prev_elig;

    always_ff @(posedge clk) begin
        if (rst) prev_elig <= '0;
        else     prev_elig <= ctx_req & ctx_active;
    end

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (cu_req_valid && !cu_done) |=> (cu_req_valid && $stable(cu_req_op)
            && $stable(cu_req_arg) && $stable(cu_req_src))); // R3

    AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctx_rsp_valid)); // R4

    AST_RSP_TO_OWNER: assert property (@(posedge clk) disable iff (rst)
        (|ctx_rsp_valid) |-> (cu_done && cu_req_valid && ctx_rsp_valid[cu_req_src])); // R4

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
        !cu_req_valid |-> (ctx_rsp_valid == '0)); // R8

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        $rose(cu_req_valid) |-> prev_elig[cu_req_src]); // R6

    AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (cu_req_valid && cu_done) |=> !cu_req_valid); // R9
endmodule

bind tcq_concentrator tcq_concentrator_chk #(.N_CTX(N_CTX)) u_chk (.*);

// File: tb/tcq_concentrator_tb.sv
`timescale 1ns/1ps
module tcq_concentrator_tb;
    import tcq_pkg::*;

    localparam int N = 2;
    localparam int IW = idx_w(N);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [N-1:0]         ctx_active = '0;
    logic [N-1:0]         ctx_req = '0;
    logic [N*OP_W-1:0]    ctx_op = '0;
    logic [N*ARG_W-1:0]   ctx_arg = '0;
    logic [N-1:0]         ctx_stall, ctx_rsp_valid;
    logic [RET_W-1:0]     ctx_rsp_data;
    logic                 cu_req_valid;
    logic [OP_W-1:0]      cu_req_op;
    logic [ARG_W-1:0]     cu_req_arg;
    logic [IW-1:0]        cu_req_src;
    logic                 cu_done = 1'b0;
    logic [RET_W-1:0]     cu_ret = '0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    tcq_concentrator #(.N_CTX(N)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic set_cmd(input int c, input logic [OP_W-1:0] op, input logic [ARG_W-1:0] arg);
        ctx_op[c*OP_W +: OP_W]    = op;
        ctx_arg[c*ARG_W +: ARG_W] = arg;
        ctx_req[c]                = 1'b1;
    endtask

    task automatic expect_grant(input int c, input logic [OP_W-1:0] op, input logic [ARG_W-1:0] arg, input string tag);
        @(negedge clk);
        chk(cu_req_valid == 1'b1, tag, cu_req_valid, 1);
        chk(cu_req_src == IW'(c), tag, cu_req_src, c);
        chk(cu_req_op == op && cu_req_arg == arg, tag, {cu_req_op, cu_req_arg}, {op, arg});
    endtask

    task automatic complete(input int c, input logic [RET_W-1:0] ret);
        cu_done = 1'b1;
        cu_ret  = ret;
        #1;
        chk(ctx_rsp_valid == N'(1 << c), "R4 rsp owner", ctx_rsp_valid, 1 << c);
        chk(ctx_rsp_data == ret, "R4 rsp data", ctx_rsp_data, ret);
        chk(ctx_stall[c] == 1'b0, "R7 stall released", ctx_stall[c], 0);
        @(negedge clk);
        cu_done    = 1'b0;
        ctx_req[c] = 1'b0;
        chk(cu_req_valid == 1'b0, "R9 idle after done", cu_req_valid, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; ctx_req = '0; cu_done = 1'b0; ctx_active = '1;
        repeat (2) @(negedge clk);
        chk(cu_req_valid == 0 && ctx_rsp_valid == 0, "R1 in reset", {cu_req_valid, ctx_rsp_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cu_req_valid == 0 && ctx_rsp_valid == 0, "R1 after reset", {cu_req_valid, ctx_rsp_valid}, 0);
    endtask

    task automatic t_single();
        set_cmd(1, 4'h3, 32'hCAFE_0001);
        #1;
        chk(ctx_stall[1] == 1'b1, "R7 stall on request", ctx_stall[1], 1);
        expect_grant(1, 4'h3, 32'hCAFE_0001, "R2 single grant");
        set_cmd(1, 4'h9, 32'h1111_2222);
        set_cmd(0, 4'h5, 32'h0000_00AA);
        repeat (2) begin
            @(negedge clk);
            chk(cu_req_src == 1 && cu_req_op == 4'h3 && cu_req_arg == 32'hCAFE_0001,
                "R3 held while busy", {cu_req_src, cu_req_op, cu_req_arg}, {1'b1, 4'h3, 32'hCAFE_0001});
            chk(ctx_stall == 2'b11, "R7 both stalled", ctx_stall, 3);
        end
        complete(1, 32'hDEAD_BEEF);
        expect_grant(0, 4'h5, 32'h0000_00AA, "R2 next grant");
        complete(0, 32'h0000_0042);
    endtask

    task automatic t_spurious_done();
        cu_done = 1'b1; cu_ret = 32'h5555_5555;
        #1;
        chk(ctx_rsp_valid == 0, "R8 stray done rsp", ctx_rsp_valid, 0);
        @(negedge clk);
        cu_done = 1'b0;
        chk(cu_req_valid == 0, "R8 stray done no cmd", cu_req_valid, 0);
    endtask

    task automatic t_contend();
        t_reset();
        set_cmd(0, 4'h1, 32'h10);
        set_cmd(1, 4'h2, 32'h20);
        expect_grant(0, 4'h1, 32'h10, "R5 ctx0 first after reset");
        for (int r = 0; r < 4; r++) begin
            int c = r % 2;
            complete(c, RET_W'(r));
            set_cmd(c, 4'h1 + OP_W'(c), ARG_W'(r + 100));
            if (c == 0) expect_grant(1, 4'h2, 32'h20 + ARG_W'(r > 0 ? r + 99 - 32 : 0), "R5 rotate to ctx1");
            else        expect_grant(0, 4'h1, ARG_W'(r + 99), "R5 rotate to ctx0");
        end
        complete(0, 32'h7);
        complete_drain();
    endtask

    task automatic complete_drain();
        @(negedge clk);
        if (cu_req_valid) complete(int'(cu_req_src), 32'h0);
        ctx_req = '0;
        @(negedge clk);
    endtask

    task automatic t_mask();
        ctx_active = 2'b01;
        set_cmd(1, 4'hE, 32'hABCD);
        repeat (3) begin
            @(negedge clk);
            chk(cu_req_valid == 0, "R6 halted ctx masked", cu_req_valid, 0);
            chk(ctx_stall[1] == 1'b1, "R7 halted ctx stalled", ctx_stall[1], 1);
        end
        ctx_active = 2'b11;
        expect_grant(1, 4'hE, 32'hABCD, "R6 granted once active");
        complete(1, 32'h0BAD);
    endtask

    initial begin
        t_reset();
        t_single();
        t_spurious_done();
        t_mask();
        t_contend();
        summary();
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule